// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Selector

This block keeps the replacement history of a set-associative cache whose sets hold eight ways, and names the way a line fill should overwrite. Every set owns seven tree bits. A hit or a fill on a way is reported through the access port (set index, way number, strobe), and at the next clock edge the block records it by rewriting the three tree bits on that way's path.

The victim query port takes a set index and that set's eight valid bits, and it answers in the same cycle. An empty way always wins over the tree: the lowest-numbered way whose valid bit is clear is chosen. Only when all eight ways are valid does the block decode the tree bits to pick the way that has gone longest without use. Cache data, tags and the memory fill lie outside this block. A synchronous clear input resets the whole history at once, for example when the cache is flushed.

Top module: `plru8_victim_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, every set's tree bits become 0. With all ways valid, such a set returns victim way 0.
- R2: If `q_valid_mask` is not 8'hFF, `victim_way` is the lowest index i for which `q_valid_mask[i]` is 0. Bit i of the mask belongs to way i.
- R3: If `q_valid_mask` is 8'hFF, the victim is decoded from tree bits t0..t6 of set `q_set` as follows. With t0=1: the victim is 7 when t2=1 and t6=1, 6 when t2=1 and t6=0, 5 when t2=0 and t5=1, and 4 when t2=0 and t5=0. With t0=0: the victim is 3 when t1=1 and t4=1, 2 when t1=1 and t4=0, 1 when t1=0 and t3=1, and 0 when t1=0 and t3=0.
- R4: An access with `acc_valid`=1 writes three bits of set `acc_set` according to `acc_way`:
  - way 0: t0, t1 and t3 become 1.
  - way 1: t0 and t1 become 1, t3 becomes 0.
  - way 2: t0 and t4 become 1, t1 becomes 0.
  - way 3: t0 becomes 1, t1 and t4 become 0.
  - way 4: t2 and t5 become 1, t0 becomes 0.
  - way 5: t2 becomes 1, t0 and t5 become 0.
  - way 6: t6 becomes 1, t0 and t2 become 0.
  - way 7: t0, t2 and t6 become 0.
- R5: An access leaves the four tree bits off its path unchanged, and it leaves every other set unchanged.
- R6: `clear`=1 at a clock edge sets every set's tree bits to 0. If an access arrives in the same cycle, the clear takes priority.
- R7: `victim_way` is combinational in `q_set`, `q_valid_mask` and the stored state. An access takes effect from the cycle after its clock edge. A query to the set being accessed in the same cycle sees the old state.
- R8: When `acc_valid` is 0, the stored state does not change, whatever `acc_set` and `acc_way` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of all replacement state |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | 3 | Way that was accessed |
| q_set | input | SET_W | Set index of the victim query |
| q_valid_mask | input | 8 | Valid bits of the queried set, bit i = way i |
| victim_way | output | 3 | Way chosen for replacement |

## Verification
The bench builds the block with NUM_SETS at 16. With only 16 sets, random accesses come back to each set often, so every set's tree passes through many of its 128 possible states. The bench can also sweep every set after a reset or a clear, which shows that no set is missed. A behavioural model holds one 7-bit value per set and applies the per-way bit patterns from an explicit table, and it is compared with `victim_way` in every cycle. Directed steps cover same-cycle query and access, clear colliding with an access, a masked strobe, and the mask patterns that decide the lowest-invalid rule.

// File: rtl/plru8_pkg.sv
// Shared constants and types for the eight-way pseudo-LRU selector.
// Assumes a fixed associativity of eight, so the tree always has seven bits.
package plru8_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = 3;
    localparam int TREE_W = WAYS - 1;

    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [WAYS-1:0]   vmask_t;
    typedef logic [TREE_W-1:0] tree_t;
endpackage

// File: rtl/plru8_tree_update.sv
// Computes the next tree state of one set after an access to a given way.
// Exactly three bits change: the root, the mid-level node chosen by the
// way's upper bit, and the leaf-level node chosen by the two upper bits.
// Each written bit points away from the accessed way.
// Assumes bit layout: t0 root, t1/t2 mid, t3..t6 leaves.
module plru8_tree_update
    import plru8_pkg::*;
(
    input  way_t  acc_way,
    input  tree_t cur_tree,
    output tree_t nxt_tree,
    output tree_t path_mask
);
    logic [2:0] mid_idx;
    logic [2:0] leaf_idx;

    // Locate the mid and leaf nodes that lie on the path to acc_way.
    always_comb begin
        mid_idx  = 3'd1 + {2'b00, acc_way[2]};
        leaf_idx = 3'd3 + {1'b0, acc_way[2:1]};
    end

    // Rewrite the three path bits so that each points to the other subtree.
    always_comb begin
        nxt_tree           = cur_tree;
        nxt_tree[0]        = ~acc_way[2];
        nxt_tree[mid_idx]  = ~acc_way[1];
        nxt_tree[leaf_idx] = ~acc_way[0];
        path_mask           = '0;
        path_mask[0]        = 1'b1;
        path_mask[mid_idx]  = 1'b1;
        path_mask[leaf_idx] = 1'b1;
    end
endmodule

// File: rtl/plru8_state_bank.sv
// Per-set tree state storage: one write port and two combinational read
// ports. Reset and clear both zero every set, and clear overrides a write.
// Assumes wr_data is already the complete next value for set wr_set.
module plru8_state_bank
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    parameter int SET_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [SET_W-1:0] wr_set,
    input  tree_t            wr_data,
    input  tree_t            wr_path,
    input  logic [SET_W-1:0] rd_a_set,
    output tree_t            rd_a_data,
    input  logic [SET_W-1:0] rd_b_set,
    output tree_t            rd_b_data
);
    tree_t tree_q [NUM_SETS];

    // Hold the tree bits: zero on reset or clear, else write the selected set.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SETS; s++) begin
            if (!rst_n || clr) begin
                tree_q[s] <= '0;
            end else if (wr_en && (wr_set == SET_W'(s))) begin
                tree_q[s] <= wr_data;
            end
        end
    end

    // Read ports: the access port reads for update, the query port for victim choice.
    assign rd_a_data = tree_q[rd_a_set];
    assign rd_b_data = tree_q[rd_b_set];

    for (genvar gs = 0; gs < NUM_SETS; gs++) begin : g_set_chk
        // A clear leaves the set at all zeros.
        assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (tree_q[gs] == '0));

        // A set that is neither written nor cleared keeps its bits.
        assert_idle_set_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !(wr_en && (wr_set == SET_W'(gs)))) |=> $stable(tree_q[gs]));

        // A write changes no bit outside the accessed path.
        assert_offpath_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && wr_en && (wr_set == SET_W'(gs))) |=>
            (((tree_q[gs] ^ $past(tree_q[gs])) & ~$past(wr_path)) == '0));
    end
endmodule

// File: rtl/plru8_victim_pick.sv
// Chooses the replacement way of one set. An invalid way wins, and among
// invalid ways the lowest index wins. With all ways valid, the tree is
// walked root to leaf, each bit steering toward the less recent half.
// Purely combinational.
module plru8_victim_pick
    import plru8_pkg::*;
(
    input  vmask_t vmask,
    input  tree_t  tree,
    output way_t   victim
);
    way_t       free_way;
    logic       upper;
    logic       mid;
    logic       leaf;
    logic [2:0] mid_idx;
    logic [2:0] leaf_idx;

    // Priority scan for the lowest-numbered invalid way.
    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vmask[w]) free_way = way_t'(w);
        end
    end

    // Tree walk: root picks the half, mid picks the pair, leaf picks the way.
    always_comb begin
        upper    = tree[0];
        mid_idx  = 3'd1 + {2'b00, upper};
        mid      = tree[mid_idx];
        leaf_idx = 3'd3 + {1'b0, upper, mid};
        leaf     = tree[leaf_idx];
    end

    // Final choice between empty-slot fill and tree replacement.
    assign victim = (&vmask) ? {upper, mid, leaf} : free_way;
endmodule

// File: rtl/plru8_victim_sel.sv
// Top of the eight-way pseudo-LRU selector. Access updates are registered
// and the victim answer is combinational from the stored state of q_set.
// Assumes the caller supplies the queried set's valid bits.
module plru8_victim_sel
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic [2:0]       acc_way,
    input  logic [SET_W-1:0] q_set,
    input  logic [7:0]       q_valid_mask,
    output logic [2:0]       victim_way
);
    tree_t acc_tree;
    tree_t acc_next;
    tree_t acc_path;
    tree_t q_tree;

    plru8_state_bank #(
        .NUM_SETS(NUM_SETS),
        .SET_W   (SET_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clear),
        .wr_en    (acc_valid),
        .wr_set   (acc_set),
        .wr_data  (acc_next),
        .wr_path  (acc_path),
        .rd_a_set (acc_set),
        .rd_a_data(acc_tree),
        .rd_b_set (q_set),
        .rd_b_data(q_tree)
    );

    plru8_tree_update u_upd (
        .acc_way  (acc_way),
        .cur_tree (acc_tree),
        .nxt_tree (acc_next),
        .path_mask(acc_path)
    );

    plru8_victim_pick u_pick (
        .vmask (q_valid_mask),
        .tree  (q_tree),
        .victim(victim_way)
    );

    // Ways below the victim; all of them must be valid when a free way is chosen.
    logic [7:0] below_victim;
    assign below_victim = (8'd1 << victim_way) - 8'd1;

    assert_free_way_chosen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid_mask != 8'hFF) |-> !q_valid_mask[victim_way]);

    assert_lowest_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid_mask != 8'hFF) |-> ((q_valid_mask & below_victim) == below_victim));
endmodule

// File: tb/plru8_victim_sel_tb_top.sv
module plru8_victim_sel_tb_top;
    localparam int NS = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [2:0]    acc_way = '0;
    logic [SW-1:0] q_set = '0;
    logic [7:0]    q_valid_mask = 8'hFF;
    logic [2:0]    victim_way;

    int   checks = 0;
    int   errors = 0;
    bit   known = 0;
    bit   done = 0;
    logic [6:0] model [NS];

    always #5 clk = ~clk;

    plru8_victim_sel #(.NUM_SETS(NS)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .acc_valid   (acc_valid),
        .acc_set     (acc_set),
        .acc_way     (acc_way),
        .q_set       (q_set),
        .q_valid_mask(q_valid_mask),
        .victim_way  (victim_way)
    );

    // Per-way bit patterns of R4, written as an explicit table.
    function automatic logic [6:0] ref_touch(input logic [6:0] s, input int w);
        logic [6:0] r = s;
        case (w)
            0: begin r[0] = 1; r[1] = 1; r[3] = 1; end
            1: begin r[0] = 1; r[1] = 1; r[3] = 0; end
            2: begin r[0] = 1; r[4] = 1; r[1] = 0; end
            3: begin r[0] = 1; r[1] = 0; r[4] = 0; end
            4: begin r[2] = 1; r[5] = 1; r[0] = 0; end
            5: begin r[2] = 1; r[0] = 0; r[5] = 0; end
            6: begin r[6] = 1; r[0] = 0; r[2] = 0; end
            default: begin r[0] = 0; r[2] = 0; r[6] = 0; end
        endcase
        return r;
    endfunction

    // R2 and R3 victim rules.
    function automatic int ref_victim(input logic [6:0] s, input logic [7:0] m);
        if (m != 8'hFF) begin
            for (int i = 0; i < 8; i++) if (!m[i]) return i;
        end
        if (s[0]) begin
            if (s[2]) return s[6] ? 7 : 6;
            return s[5] ? 5 : 4;
        end
        if (s[1]) return s[4] ? 3 : 2;
        return s[3] ? 1 : 0;
    endfunction

    // Drive one cycle of stimulus, compare the victim, then advance the model.
    task automatic step(input bit rv, input bit cl, input bit av, input int aset,
                        input int aw, input int qset, input logic [7:0] qm,
                        input string tag);
        int exp;
        @(negedge clk);
        rst_n = rv; clear = cl; acc_valid = av;
        acc_set = aset[SW-1:0]; acc_way = aw[2:0];
        q_set = qset[SW-1:0]; q_valid_mask = qm;
        #1;
        if (known) begin
            exp = ref_victim(model[qset], qm);
            checks++;
            if (victim_way !== 3'(exp)) begin
                errors++;
                $display("FAIL %s: set %0d mask %h victim actual %0d expected %0d",
                         tag, qset, qm, victim_way, exp);
            end
        end
        @(posedge clk);
        if (!rv || cl) begin
            for (int s = 0; s < NS; s++) model[s] = '0;
            known = 1;
        end else if (av) begin
            model[aset] = ref_touch(model[aset], aw);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] masks [7] = '{8'h00, 8'h01, 8'h0F, 8'hF7, 8'h7F, 8'hFE, 8'hBF};
        // R1: reset, with an access driven that must be overridden.
        repeat (3) step(0, 0, 1, 2, 5, 2, 8'hFF, "R1");
        for (int s = 0; s < NS; s++) step(1, 0, 0, 0, 0, s, 8'hFF, "R1");
        // R2: invalid-way priority.
        for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, 0, masks[i], "R2");
        // R4 and R3: walk every way on set 3 and decode the tree afterwards.
        for (int w = 0; w < 8; w++) begin
            step(1, 0, 1, 3, w, 3, 8'hFF, "R4");
            step(1, 0, 0, 3, w, 3, 8'hFF, "R3");
        end
        // R7: same-cycle query sees old state (0), next cycle sees way 4.
        step(1, 0, 1, 5, 0, 5, 8'hFF, "R7");
        step(1, 0, 0, 5, 0, 5, 8'hFF, "R7");
        // R8: strobe low, set and way driven; victim stays 4.
        step(1, 0, 0, 5, 3, 5, 8'hFF, "R8");
        step(1, 0, 0, 5, 3, 5, 8'hFF, "R8");
        // R5: way 0 then way 4 on set 6 keeps t1/t3, so the victim is 2; set 5 untouched.
        step(1, 0, 1, 6, 0, 6, 8'hFF, "R5");
        step(1, 0, 1, 6, 4, 6, 8'hFF, "R5");
        step(1, 0, 0, 6, 0, 6, 8'hFF, "R5");
        step(1, 0, 0, 6, 0, 5, 8'hFF, "R5");
        // R6: clear wins over a simultaneous access; every set reads back zero.
        step(1, 1, 1, 6, 0, 6, 8'hFF, "R6");
        for (int s = 0; s < NS; s++) step(1, 0, 0, 0, 0, s, 8'hFF, "R6");
        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            bit         cl = ($urandom % 250) == 0;
            bit         av = ($urandom % 4) != 0;
            logic [7:0] m  = (($urandom % 4) == 0) ? 8'($urandom) : 8'hFF;
            step(1, cl, av, int'($urandom % NS), int'($urandom % 8),
                 int'($urandom % NS), m, "R3");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule